// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block sits in a PCIe root-complex bridge and rewrites outbound request addresses before they become packets on the link. It keeps a bank of translation regions. Each region has a 64-bit base, a 32-bit inclusive end, a 64-bit target, a packet-type field, a hint flag, an enable bit and a configuration shift-mode bit. For every request address the unit finds the lowest-numbered enabled region that contains the address. It then returns the rebased address, the packet type, the hint and a hit flag. When no region matches, the address passes through unchanged.

Software programs the regions through a small 32-bit register bus. A viewport word chooses which region's seven shadow words are visible in the register window, so all regions share one window of eight addresses. In configuration shift mode the offset inside a region is re-laid out. Its bus/device/function part moves up to the position a configuration header uses, and its register-offset part stays where it is. A flat aperture of memory-mapped configuration space can then be turned into configuration addresses.

Top module: `outbound_xlat`

## Requirements
- R1: After synchronous reset every region is disabled. rsp_valid, rsp_hit, rsp_addr, rsp_type, rsp_hint, rsp_region and cfg_rdata are all zero.
- R2: The viewport word sits at window offset 0x00 (default address 0x900). Its bits [2:0] select the region and bit 31 selects inbound (1) or outbound (0). It reads back as exactly those bits, with every other bit reading zero.
- R3: The region words follow the viewport at 4-byte steps in this order: control 1 (+0x04), control 2 (+0x08), base low, base high, end low, target low, target high (+0x1C). Each reads back exactly the 32-bit value last written to the region the viewport selects. Read data appears on cfg_rdata on the cycle after cfg_rd_en and is held until the next read.
- R4: While viewport bit 31 is 1, writes to region words have no effect and reads of region words return zero.
- R5: A region matches when control 2 bit 31 is 1 and base <= address <= {base high, end low}. The end is inclusive, and its upper 32 bits are taken from base high. A region with bit 31 clear never matches.
- R6: On a hit, rsp_addr = target + (address - base). rsp_type is control 1 bits [4:0], where memory = 0x0, I/O = 0x2, type-0 configuration = 0x4 and type-1 configuration = 0x5. rsp_hint is control 1 bit 12, and rsp_region is the index of the matching region.
- R7: When control 2 bit 28 is set, the offset (address - base) is remapped before the target is added. Offset bits [27:12] move to bits [31:16], bits [11:0] stay in place, and all other bits become zero.
- R8: When several enabled regions contain the address, the one with the lowest index is used.
- R9: On a miss, rsp_hit is 0, rsp_addr equals the request address, and rsp_type, rsp_hint and rsp_region are zero.
- R10: Results appear one cycle after the request is presented, and rsp_valid is req_valid delayed by one cycle. A register write in the same cycle as a request takes effect from the next request.
- R11: Addresses outside the eight-word window, and addresses that are not word-aligned, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Outbound request address |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A region matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_type | output | 5 | Packet type of the matching region |
| rsp_hint | output | 1 | Hint flag of the matching region |
| rsp_region | output | IDX_W | Index of the matching region |

## Verification
The bench uses the default parameters: eight regions, a 12-bit register address and the window at 0x900. With these values all eight viewport indices map onto real regions. The register window can be probed on both sides and at a misaligned address. Regions are laid out so that a 32-bit memory aperture, type-0 and type-1 shifted configuration apertures, an I/O aperture and a region above 4 GiB all sit side by side. An overlapping higher-index region and a disabled region are placed where priority and enable gating show up at the result ports.

// File: rtl/outbound_xlat_pkg.sv
package outbound_xlat_pkg;

  localparam int WORD_W       = 32;
  localparam int XADDR_W      = 64;
  localparam int TYPE_W       = 5;

  // bit positions decoded by the translator
  localparam int VP_DIR_BIT   = 31;
  localparam int C2_EN_BIT    = 31;
  localparam int C2_SHIFT_BIT = 28;
  localparam int C1_HINT_BIT  = 12;

  // configuration shift-mode remap
  localparam int BDF_SRC_LO   = 12;
  localparam int BDF_SRC_HI   = 27;
  localparam int BDF_DST_LO   = 16;
  localparam int REGOFF_W     = 12;

  // word slots inside the register window; the order is software-visible
  typedef enum logic [2:0] {
    W_VIEW    = 3'd0,
    W_CTRL1   = 3'd1,
    W_CTRL2   = 3'd2,
    W_BASE_LO = 3'd3,
    W_BASE_HI = 3'd4,
    W_END_LO  = 3'd5,
    W_TGT_LO  = 3'd6,
    W_TGT_HI  = 3'd7
  } win_word_e;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl1;
    logic [WORD_W-1:0] ctrl2;
    logic [WORD_W-1:0] base_lo;
    logic [WORD_W-1:0] base_hi;
    logic [WORD_W-1:0] end_lo;
    logic [WORD_W-1:0] tgt_lo;
    logic [WORD_W-1:0] tgt_hi;
  } region_cfg_t;

  function automatic logic [XADDR_W-1:0] rgn_base(region_cfg_t r);
    return {r.base_hi, r.base_lo};
  endfunction

  function automatic logic [XADDR_W-1:0] rgn_end(region_cfg_t r);
    return {r.base_hi, r.end_lo};
  endfunction

  function automatic logic [XADDR_W-1:0] rgn_tgt(region_cfg_t r);
    return {r.tgt_hi, r.tgt_lo};
  endfunction

endpackage

// File: rtl/outbound_xlat_regs.sv
module outbound_xlat_regs
  import outbound_xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = 12,
  parameter logic [CFG_AW-1:0] WIN_BASE = 'h900,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output region_cfg_t       regions_o [NUM_REGIONS],
  output logic              vp_inbound_o
);

  localparam int WIN_WORDS = 8;
  localparam int WIN_BYTES = WIN_WORDS * (WORD_W / 8);

  logic [CFG_AW-1:0] rel;
  logic              in_win;
  win_word_e         word;
  logic [IDX_W-1:0]  idx_q;
  logic              inb_q;
  logic              idx_ok;
  logic              rgn_access;
  region_cfg_t       cur;
  logic [WORD_W-1:0] rd_word;

  assign rel    = cfg_addr - WIN_BASE;
  assign in_win = (cfg_addr >= WIN_BASE) && (rel < CFG_AW'(WIN_BYTES)) &&
                  (cfg_addr[1:0] == 2'b00);
  assign word   = win_word_e'(rel[4:2]);

  generate
    if (NUM_REGIONS == (1 << IDX_W)) begin : g_full_idx
      assign idx_ok = 1'b1;
    end else begin : g_part_idx
      assign idx_ok = ({1'b0, idx_q} < (IDX_W+1)'(NUM_REGIONS));
    end
  endgenerate

  assign rgn_access = in_win && (word != W_VIEW) && !inb_q && idx_ok;

  // viewport: region index and direction
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      inb_q <= 1'b0;
    end else if (cfg_wr_en && in_win && (word == W_VIEW)) begin
      idx_q <= cfg_wdata[IDX_W-1:0];
      inb_q <= cfg_wdata[VP_DIR_BIT];
    end
  end

  assign vp_inbound_o = inb_q;

  // shadow words, one bank per region
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    region_cfg_t q;
    logic        wr_sel;

    assign wr_sel = cfg_wr_en && rgn_access && (idx_q == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_sel) begin
        case (word)
          W_CTRL1:   q.ctrl1   <= cfg_wdata;
          W_CTRL2:   q.ctrl2   <= cfg_wdata;
          W_BASE_LO: q.base_lo <= cfg_wdata;
          W_BASE_HI: q.base_hi <= cfg_wdata;
          W_END_LO:  q.end_lo  <= cfg_wdata;
          W_TGT_LO:  q.tgt_lo  <= cfg_wdata;
          W_TGT_HI:  q.tgt_hi  <= cfg_wdata;
          default:   ;
        endcase
      end
    end

    assign regions_o[g] = q;
  end

  // read path
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (idx_q == IDX_W'(i)) cur = regions_o[i];
    end
  end

  always_comb begin
    rd_word = '0;
    if (in_win && (word == W_VIEW)) begin
      rd_word[IDX_W-1:0] = idx_q;
      rd_word[VP_DIR_BIT] = inb_q;
    end else if (rgn_access) begin
      case (word)
        W_CTRL1:   rd_word = cur.ctrl1;
        W_CTRL2:   rd_word = cur.ctrl2;
        W_BASE_LO: rd_word = cur.base_lo;
        W_BASE_HI: rd_word = cur.base_hi;
        W_END_LO:  rd_word = cur.end_lo;
        W_TGT_LO:  rd_word = cur.tgt_lo;
        W_TGT_HI:  rd_word = cur.tgt_hi;
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cfg_rdata <= '0;
    else if (cfg_rd_en) cfg_rdata <= rd_word;
  end

endmodule

// File: rtl/outbound_xlat_match.sv
module outbound_xlat_match
  import outbound_xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  region_cfg_t              regions_i [NUM_REGIONS],
  input  logic [XADDR_W-1:0]       addr_i,
  output logic [NUM_REGIONS-1:0]   en_o,
  output logic [NUM_REGIONS-1:0]   hit_o
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [XADDR_W-1:0] lo;
    logic [XADDR_W-1:0] hi;
    logic               unused_fields;

    assign lo       = rgn_base(regions_i[g]);
    assign hi       = rgn_end(regions_i[g]);
    assign en_o[g]  = regions_i[g].ctrl2[C2_EN_BIT];
    assign hit_o[g] = en_o[g] && (addr_i >= lo) && (addr_i <= hi);

    assign unused_fields = ^{regions_i[g].ctrl1, regions_i[g].tgt_lo,
                             regions_i[g].tgt_hi, regions_i[g].ctrl2[30:0]};
  end

endmodule

// File: rtl/outbound_xlat_pick.sv
module outbound_xlat_pick
  import outbound_xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  region_cfg_t             regions_i [NUM_REGIONS],
  input  logic [NUM_REGIONS-1:0]  hit_i,
  input  logic [XADDR_W-1:0]      addr_i,
  output logic [NUM_REGIONS-1:0]  gnt_o,
  output logic                    hit_o,
  output logic [XADDR_W-1:0]      addr_o,
  output logic [TYPE_W-1:0]       type_o,
  output logic                    hint_o,
  output logic [IDX_W-1:0]        idx_o
);

  region_cfg_t        win;
  logic [XADDR_W-1:0] off;
  logic [XADDR_W-1:0] off_m;
  logic               unused_pick;

  // lowest index wins: later (lower) iterations overwrite
  always_comb begin
    gnt_o = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  // AND-OR selection of the granted region
  always_comb begin
    win   = '0;
    idx_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (gnt_o[i]) begin
        win   = region_cfg_t'(win | regions_i[i]);
        idx_o = idx_o | IDX_W'(i);
      end
    end
  end

  assign hit_o = |hit_i;
  assign off   = addr_i - rgn_base(win);

  always_comb begin
    if (win.ctrl2[C2_SHIFT_BIT]) begin
      off_m = '0;
      off_m[REGOFF_W-1:0] = off[REGOFF_W-1:0];
      off_m[BDF_DST_LO + (BDF_SRC_HI - BDF_SRC_LO) : BDF_DST_LO] =
        off[BDF_SRC_HI:BDF_SRC_LO];
    end else begin
      off_m = off;
    end
  end

  assign addr_o = hit_o ? (rgn_tgt(win) + off_m) : addr_i;
  assign type_o = win.ctrl1[TYPE_W-1:0];
  assign hint_o = win.ctrl1[C1_HINT_BIT];

  assign unused_pick = ^{win.ctrl1[31:C1_HINT_BIT+1], win.ctrl1[C1_HINT_BIT-1:TYPE_W],
                         win.ctrl2[31:C2_SHIFT_BIT+1], win.ctrl2[C2_SHIFT_BIT-1:0],
                         win.end_lo, off[XADDR_W-1:BDF_SRC_HI+1]};

endmodule

// File: rtl/outbound_xlat.sv
module outbound_xlat
  import outbound_xlat_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = 12,
  parameter logic [CFG_AW-1:0] WIN_BASE = 'h900,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [63:0]       rsp_addr,
  output logic [4:0]        rsp_type,
  output logic              rsp_hint,
  output logic [IDX_W-1:0]  rsp_region
);

  region_cfg_t            regions [NUM_REGIONS];
  logic                   vp_inbound;
  logic [NUM_REGIONS-1:0] en_vec;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] gnt_vec;
  logic                   c_hit;
  logic [XADDR_W-1:0]     c_addr;
  logic [TYPE_W-1:0]      c_type;
  logic                   c_hint;
  logic [IDX_W-1:0]       c_idx;

  outbound_xlat_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .CFG_AW      (CFG_AW),
    .WIN_BASE    (WIN_BASE)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .regions_o    (regions),
    .vp_inbound_o (vp_inbound)
  );

  outbound_xlat_match #(
    .NUM_REGIONS (NUM_REGIONS)
  ) u_match (
    .regions_i (regions),
    .addr_i    (req_addr),
    .en_o      (en_vec),
    .hit_o     (hit_vec)
  );

  outbound_xlat_pick #(
    .NUM_REGIONS (NUM_REGIONS)
  ) u_pick (
    .regions_i (regions),
    .hit_i     (hit_vec),
    .addr_i    (req_addr),
    .gnt_o     (gnt_vec),
    .hit_o     (c_hit),
    .addr_o    (c_addr),
    .type_o    (c_type),
    .hint_o    (c_hint),
    .idx_o     (c_idx)
  );

  // registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_addr   <= '0;
      rsp_type   <= '0;
      rsp_hint   <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= c_hit;
      rsp_addr   <= c_addr;
      rsp_type   <= c_type;
      rsp_hint   <= c_hint;
      rsp_region <= c_idx;
    end
  end

endmodule

// File: rtl/outbound_xlat_chk.sv
module outbound_xlat_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int CFG_AW      = 12,
  parameter logic [CFG_AW-1:0] WIN_BASE = 'h900
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic [63:0]            req_addr,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic [63:0]            rsp_addr,
  input logic [4:0]             rsp_type,
  input logic                   rsp_hint,
  input logic                   cfg_rd_en,
  input logic [CFG_AW-1:0]      cfg_addr,
  input logic [31:0]            cfg_rdata,
  input logic                   vp_inbound,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic [NUM_REGIONS-1:0] gnt_vec
);

  logic [CFG_AW-1:0] rel;
  logic              rgn_word;

  assign rel      = cfg_addr - WIN_BASE;
  assign rgn_word = (cfg_addr >= WIN_BASE) && (rel >= CFG_AW'(4)) &&
                    (rel < CFG_AW'(32)) && (rel[1:0] == 2'b00);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_hit && (cfg_rdata == 32'd0)));

  p_inbound_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && vp_inbound && rgn_word) |=> (cfg_rdata == 32'd0));

  p_grant_among_hits_r8: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) |-> ($onehot(gnt_vec) && ((gnt_vec & ~hit_vec) == '0)));

  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (rst)
    (((gnt_vec - NUM_REGIONS'(1)) & hit_vec) == '0) || (gnt_vec == '0));

  p_no_grant_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_vec == '0) |-> (gnt_vec == '0));

  p_miss_passthru_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |->
      ((rsp_addr == $past(req_addr)) && (rsp_type == 5'd0) && !rsp_hint));

  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_delay_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

endmodule

bind outbound_xlat outbound_xlat_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .CFG_AW      (CFG_AW),
  .WIN_BASE    (WIN_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_addr   (rsp_addr),
  .rsp_type   (rsp_type),
  .rsp_hint   (rsp_hint),
  .cfg_rd_en  (cfg_rd_en),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .vp_inbound (vp_inbound),
  .hit_vec    (hit_vec),
  .gnt_vec    (gnt_vec)
);

// File: tb/outbound_xlat_bench.sv
`timescale 1ns/1ps
module outbound_xlat_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_hint;
  logic [63:0] rsp_addr;
  logic [4:0]  rsp_type;
  logic [2:0]  rsp_region;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    started  = 0;
  bit    done     = 0;
  string phase    = "R1";

  always #4 clk = ~clk;   // 125 MHz

  outbound_xlat u_outbound_xlat (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_type(rsp_type),
    .rsp_hint(rsp_hint), .rsp_region(rsp_region)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_reg [8][7];   // word 0 = control 1 ... 6 = target high
  int          m_idx;
  bit          m_inb;
  logic        e_valid, e_hit, e_hint;
  logic [63:0] e_addr;
  logic [4:0]  e_type;
  int          e_reg;
  logic [31:0] e_rdata;

  function automatic logic [31:0] m_read(logic [11:0] a);
    int w;
    if (a < 12'h900 || a >= 12'h920 || a[1:0] != 2'b00) return 32'h0;
    w = (int'(a) - 'h900) / 4;
    if (w == 0) return {m_inb, 28'h0, 3'(m_idx)};
    if (m_inb) return 32'h0;
    return m_reg[m_idx][w-1];
  endfunction

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    int w;
    if (a < 12'h900 || a >= 12'h920 || a[1:0] != 2'b00) return;
    w = (int'(a) - 'h900) / 4;
    if (w == 0) begin
      m_idx = int'(d[2:0]);
      m_inb = d[31];
    end else if (!m_inb) begin
      m_reg[m_idx][w-1] = d;
    end
  endtask

  task automatic m_xlat(logic [63:0] a);
    logic [63:0] b, lim, t, off;
    e_hit = 0; e_addr = a; e_type = 0; e_hint = 0; e_reg = 0;
    for (int i = 0; i < 8; i++) begin
      b   = {m_reg[i][3], m_reg[i][2]};
      lim = {m_reg[i][3], m_reg[i][4]};
      t   = {m_reg[i][6], m_reg[i][5]};
      if (m_reg[i][1][31] && a >= b && a <= lim) begin
        off = a - b;
        if (m_reg[i][1][28])
          off = (((off >> 12) & 64'hFFFF) << 16) | (off & 64'hFFF);
        e_hit  = 1;
        e_addr = t + off;
        e_type = m_reg[i][0][4:0];
        e_hint = m_reg[i][0][12];
        e_reg  = i;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 7; j++) m_reg[i][j] = '0;
      m_idx = 0; m_inb = 0;
      e_valid = 0; e_hit = 0; e_addr = 0; e_type = 0; e_hint = 0; e_reg = 0;
      e_rdata = 0;
    end else begin
      e_valid = req_valid;
      m_xlat(req_addr);
      if (cfg_rd_en) e_rdata = m_read(cfg_addr);
      if (cfg_wr_en) m_write(cfg_addr, cfg_wdata);
    end
    started = 1;
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      n_checks++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_addr !== e_addr ||
          rsp_type !== e_type || rsp_hint !== e_hint ||
          rsp_region !== 3'(e_reg) || cfg_rdata !== e_rdata) begin
        n_fail++;
        $display("FAIL %s model: act v=%0b h=%0b a=%h t=%h n=%0b r=%0d rd=%h exp v=%0b h=%0b a=%h t=%h n=%0b r=%0d rd=%h",
                 phase, rsp_valid, rsp_hit, rsp_addr, rsp_type, rsp_hint, rsp_region, cfg_rdata,
                 e_valid, e_hit, e_addr, e_type, e_hint, e_reg, e_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk);
    cfg_rd_en = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 0;
  endtask

  task automatic req(logic [63:0] a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic prog(int idx, logic [31:0] c1, logic [31:0] c2, logic [63:0] b,
                      logic [31:0] lim, logic [63:0] t);
    wr(12'h900, 32'(idx));
    wr(12'h904, c1);
    wr(12'h908, c2);
    wr(12'h90C, b[31:0]);
    wr(12'h910, b[63:32]);
    wr(12'h914, lim);
    wr(12'h918, t[31:0]);
    wr(12'h91C, t[63:32]);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk("R1 cfg_rdata after reset", 64'(cfg_rdata), 0);
    req(64'h8000_0000);
    chk("R1 no region enabled after reset", 64'(rsp_hit), 0);

    phase = "R2";
    wr(12'h900, 32'hFFFF_FFF5);
    rd(12'h900);
    chk("R2 viewport readback", 64'(cfg_rdata), 64'h8000_0005);

    phase = "R4";
    wr(12'h904, 32'h0000_1234);
    rd(12'h904);
    chk("R4 inbound read zero", 64'(cfg_rdata), 0);
    wr(12'h900, 32'h5);
    rd(12'h904);
    chk("R4 inbound write ignored", 64'(cfg_rdata), 0);

    phase = "R3";
    prog(2, 32'hA5A5_1005, 32'h1234_5678, 64'h0BAD_F00D_CAFE_0000, 32'hCAFE_FFFF,
         64'h7777_6666_5555_4444);
    wr(12'h900, 32'h2);
    rd(12'h904); chk("R3 control 1", 64'(cfg_rdata), 64'hA5A5_1005);
    rd(12'h908); chk("R3 control 2", 64'(cfg_rdata), 64'h1234_5678);
    rd(12'h90C); chk("R3 base low", 64'(cfg_rdata), 64'hCAFE_0000);
    rd(12'h910); chk("R3 base high", 64'(cfg_rdata), 64'h0BAD_F00D);
    rd(12'h914); chk("R3 end low", 64'(cfg_rdata), 64'hCAFE_FFFF);
    rd(12'h918); chk("R3 target low", 64'(cfg_rdata), 64'h5555_4444);
    rd(12'h91C); chk("R3 target high", 64'(cfg_rdata), 64'h7777_6666);
    wr(12'h900, 32'h3);
    rd(12'h904); chk("R3 other region untouched", 64'(cfg_rdata), 0);

    phase = "R11";
    wr(12'h920, 32'hFFFF_FFFF);
    rd(12'h920); chk("R11 past window", 64'(cfg_rdata), 0);
    rd(12'h8FC); chk("R11 below window", 64'(cfg_rdata), 0);
    wr(12'h906, 32'hFFFF_FFFF);
    rd(12'h906); chk("R11 misaligned", 64'(cfg_rdata), 0);
    rd(12'h904); chk("R11 misaligned write ignored", 64'(cfg_rdata), 0);

    phase = "R6";
    prog(0, 32'h0000_1000, 32'h8000_0000, 64'h8000_0000, 32'h8FFF_FFFF, 64'h1000_0000);
    prog(1, 32'h4, 32'h9000_0000, 64'h6000_0000, 32'h6000_FFFF, 64'h0);
    prog(2, 32'h5, 32'h9000_0000, 64'h6001_0000, 32'h67EF_FFFF, 64'h0);
    prog(3, 32'h2, 32'h8000_0000, 64'h67F0_0000, 32'h67FF_FFFF, 64'h0);
    prog(4, 32'h0000_1000, 32'h8000_0000, 64'h8_0000_0000, 32'hFFFF_FFFF, 64'h40_0000_0000);
    prog(5, 32'h0, 32'h8000_0000, 64'h8800_0000, 32'h88FF_FFFF, 64'h2_0000_0000);
    prog(6, 32'h0, 32'h0, 64'h9000_0000, 32'h9000_FFFF, 64'h5000_0000);

    req(64'h8123_4567);
    chk("R6 memory rebase", rsp_addr, 64'h1123_4567);
    chk("R6 memory hint", 64'(rsp_hint), 1);
    req(64'h67F0_0010);
    chk("R6 io rebase", rsp_addr, 64'h10);
    chk("R6 io type", 64'(rsp_type), 2);
    chk("R6 io region", 64'(rsp_region), 3);
    req(64'h8_0000_1000);
    chk("R6 region above 4G", rsp_addr, 64'h40_0000_1000);

    phase = "R5";
    req(64'h8000_0000);
    chk("R5 base inclusive", 64'(rsp_hit), 1);
    req(64'h67FF_FFFF);
    chk("R5 end inclusive", rsp_addr, 64'h000F_FFFF);
    req(64'h9_0000_0000);
    chk("R5 beyond upper end", 64'(rsp_hit), 0);
    req(64'h9000_0004);
    chk("R5 disabled region", 64'(rsp_hit), 0);

    phase = "R7";
    req(64'h6000_F123);
    chk("R7 type-0 shift", rsp_addr, 64'h000F_0123);
    chk("R7 type-0 type", 64'(rsp_type), 4);
    req(64'h6012_3ABC);
    chk("R7 type-1 shift", rsp_addr, 64'h0113_0ABC);
    chk("R7 type-1 type", 64'(rsp_type), 5);

    phase = "R9";
    req(64'h6800_0000);
    chk("R9 miss passthrough", rsp_addr, 64'h6800_0000);
    chk("R9 miss type", 64'(rsp_type), 0);

    phase = "R8";
    req(64'h8800_0040);
    chk("R8 lowest index wins", rsp_addr, 64'h1800_0040);
    chk("R8 winner index", 64'(rsp_region), 0);
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    req(64'h8800_0040);
    chk("R8 next region after disable", rsp_addr, 64'h2_0000_0040);

    phase = "R10";
    wr(12'h900, 32'h6);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = 12'h908; cfg_wdata = 32'h8000_0000;
    req_valid = 1; req_addr = 64'h9000_0004;
    @(negedge clk);
    cfg_wr_en = 0; req_valid = 0;
    chk("R10 same-cycle write not seen", 64'(rsp_hit), 0);
    chk("R10 valid after one cycle", 64'(rsp_valid), 1);
    req(64'h9000_0004);
    chk("R10 write seen next request", rsp_addr, 64'h5000_0004);

    phase = "R6";
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      case ($urandom % 6)
        0: a = 64'h8000_0000 + 64'($urandom % 32'h1000_0100);
        1: a = 64'h6000_0000 + 64'($urandom % 32'h0800_0100);
        2: a = 64'h8_0000_0000 + 64'($urandom);
        3: a = {32'($urandom % 16), 32'($urandom)};
        4: a = 64'h8800_0000 + 64'($urandom % 32'h0100_0100);
        default: a = 64'h9000_0000 + 64'($urandom % 32'h0002_0000);
      endcase
      @(negedge clk);
      req_valid = ($urandom % 4) != 0;
      req_addr  = a;
    end
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule